// File: doc/BRIEF.md
# Gated multi-mode counter/timer

One counter/timer channel of the kind found beside a small 8-bit processor core. Two count bytes, a low one and a high one, form either a 13-bit counter, a 16-bit counter or an 8-bit counter that reloads itself. When the count wraps, a sticky overflow flag is set. If the interrupt enable is on, the flag also drives an interrupt request.

Each increment needs two things: an enable and a tick. The enable is a run bit. It can also be qualified by an external gate pin whose active level is programmable. The tick comes from one of three sources: every system clock, a prescaled system clock (one tick per `PRE_DIV` clocks), or falling edges of an external count pin after a synchronizer. Software loads the count bytes, the control byte and the flag clear through a single write port, and it reads all state back on dedicated outputs.

Top module: `gmt_timer`

## Requirements
- R1: After reset, lo_q, hi_q, ctl_q, ovf_flag and irq are all 0.
- R2: Mode field ctl[1:0]=0 counts the 13-bit value {hi_q, lo_q[4:0]}. lo_q[7:5] are never changed by counting. A step from 0x1FFF wraps to 0 and sets ovf_flag.
- R3: Mode field 1 counts the 16-bit value {hi_q, lo_q}. A step from 0xFFFF wraps to 0x0000 and sets ovf_flag. There is no reload.
- R4: Mode field 2 counts lo_q only. A step from 0xFF loads lo_q from hi_q and sets ovf_flag. Counting never changes hi_q.
- R5: Mode field 3 never changes the count.
- R6: Counting is enabled when run (ctl[2]) is 1 and either gate (ctl[3]) is 0 or (gate_pin XOR pol) is 1, where pol is ctl[4]. gate_pin passes through a two-flop synchronizer first.
- R7: With ext (ctl[5])=1, the counter steps once per falling edge of count_pin, seen after a two-flop synchronizer. Rising edges do not step it. With ext=0 and sys (ctl[6])=1 it steps on every clock. With ext=0 and sys=0 it steps once per PRE_DIV clocks.
- R8: A write with waddr 0 loads lo_q, waddr 1 loads hi_q and waddr 2 loads ctl_q. All loads take effect at the next edge. A count-byte write blocks the increment in that same cycle.
- R9: ovf_flag stays set until a write with waddr 3. If an overflow occurs in the same cycle as that write, the flag stays set.
- R10: irq is 1 exactly when ovf_flag is 1 and the interrupt enable (ctl[7]) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| waddr | input | 2 | 0 low byte, 1 high byte, 2 control, 3 flag clear |
| wdata | input | 8 | Write data |
| gate_pin | input | 1 | External gate, asynchronous |
| count_pin | input | 1 | External count input, asynchronous |
| lo_q | output | 8 | Low count byte |
| hi_q | output | 8 | High count byte / reload value |
| ctl_q | output | 8 | Control byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong carry split or a wrong reload path shows up in lo_q/hi_q no later than the first overflow of a run: a wrong wrap value or a flag that stays low. A wrong enable or tick path appears as a wrong increment count after a short run window. Every window is exact in clock edges, so the error shows up in the very next readback. Errors in the synchronizer or in the edge polarity change the number of external-edge increments by at least one within a few pin toggles.

// File: rtl/gmt_pkg.sv
package gmt_pkg;
  localparam int BYTE_W = 8;
  localparam int M0_LO_BITS = 5;

  typedef enum logic [1:0] {
    MD_13BIT = 2'd0,
    MD_16BIT = 2'd1,
    MD_RELOAD8 = 2'd2,
    MD_HOLD = 2'd3
  } gmt_mode_e;

  typedef struct packed {
    logic       int_en;
    logic       sys_src;
    logic       ext_src;
    logic       pol;
    logic       gate;
    logic       run;
    gmt_mode_e  mode;
  } gmt_ctl_t;

  typedef struct packed {
    logic              ovf;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } gmt_step_t;

  // one increment of the count bytes for the given mode
  function automatic gmt_step_t gmt_step(gmt_mode_e md, logic [BYTE_W-1:0] lo,
                                         logic [BYTE_W-1:0] hi);
    gmt_step_t r;
    logic [BYTE_W+M0_LO_BITS:0] c13;
    logic [2*BYTE_W:0] c16;
    r = '{ovf: 1'b0, hi: hi, lo: lo};
    c13 = '0;
    c16 = '0;
    case (md)
      MD_13BIT: begin
        c13 = {1'b0, hi, lo[M0_LO_BITS-1:0]} + 1'b1;
        r.ovf = c13[BYTE_W+M0_LO_BITS];
        r.hi = c13[BYTE_W+M0_LO_BITS-1:M0_LO_BITS];
        r.lo = {lo[BYTE_W-1:M0_LO_BITS], c13[M0_LO_BITS-1:0]};
      end
      MD_16BIT: begin
        c16 = {1'b0, hi, lo} + 1'b1;
        r.ovf = c16[2*BYTE_W];
        r.hi = c16[2*BYTE_W-1:BYTE_W];
        r.lo = c16[BYTE_W-1:0];
      end
      MD_RELOAD8: begin
        r.ovf = &lo;
        r.lo = r.ovf ? hi : lo + 1'b1;
      end
      default: r = '{ovf: 1'b0, hi: hi, lo: lo};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gmt_sync.sv
module gmt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rst_val,
  output logic q,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= {(STAGES+1){rst_val}};
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign q = sh[STAGES-1];
  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/gmt_tick_sel.sv
module gmt_tick_sel #(
  parameter int PRE_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_src,
  input  logic sys_src,
  input  logic ext_fall,
  output logic tick
);
  logic pre_tick;

  generate
    if (PRE_DIV <= 1) begin : g_nodiv
      assign pre_tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] pre_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)              pre_cnt <= '0;
        else if (pre_cnt == LAST) pre_cnt <= '0;
        else                     pre_cnt <= pre_cnt + 1'b1;
      end
      assign pre_tick = (pre_cnt == LAST);
    end
  endgenerate

  always_comb begin
    if (ext_src)      tick = ext_fall;
    else if (sys_src) tick = 1'b1;
    else              tick = pre_tick;
  end
endmodule

// File: rtl/gmt_core.sv
module gmt_core
  import gmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  gmt_mode_e         mode,
  input  logic              inc,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              clr_flag,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              flag,
  output logic              ovf_evt
);
  gmt_step_t nxt;

  assign nxt = gmt_step(mode, lo, hi);
  assign ovf_evt = inc & nxt.ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      if (wr_lo)    lo <= wdata;
      else if (inc) lo <= nxt.lo;
      if (wr_hi)    hi <= wdata;
      else if (inc) hi <= nxt.hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (ovf_evt)  flag <= 1'b1;
    else if (clr_flag) flag <= 1'b0;
  end
endmodule

// File: rtl/gmt_timer.sv
module gmt_timer
  import gmt_pkg::*;
#(
  parameter int PRE_DIV = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] waddr,
  input  logic [7:0] wdata,
  input  logic       gate_pin,
  input  logic       count_pin,
  output logic [7:0] lo_q,
  output logic [7:0] hi_q,
  output logic [7:0] ctl_q,
  output logic       ovf_flag,
  output logic       irq
);
  gmt_ctl_t ctl;
  logic wr_lo, wr_hi, wr_ctl, clr_flag;
  logic gate_s, gate_unused_fall, cnt_s_unused, ext_fall;
  logic gate_act, cnt_en, tick, inc, ovf_evt;

  assign wr_lo    = wr_en & (waddr == 2'd0);
  assign wr_hi    = wr_en & (waddr == 2'd1);
  assign wr_ctl   = wr_en & (waddr == 2'd2);
  assign clr_flag = wr_en & (waddr == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl <= '0;
    else if (wr_ctl) ctl <= gmt_ctl_t'(wdata);
  end

  gmt_sync #(.STAGES(SYNC_STAGES)) u_gsync (
    .clk(clk), .rst_n(rst_n), .pin(gate_pin), .rst_val(1'b0),
    .q(gate_s), .fall(gate_unused_fall));

  gmt_sync #(.STAGES(SYNC_STAGES)) u_csync (
    .clk(clk), .rst_n(rst_n), .pin(count_pin), .rst_val(1'b1),
    .q(cnt_s_unused), .fall(ext_fall));

  gmt_tick_sel #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_src(ctl.ext_src), .sys_src(ctl.sys_src),
    .ext_fall(ext_fall), .tick(tick));

  assign gate_act = gate_s ^ ctl.pol;
  assign cnt_en   = ctl.run & (~ctl.gate | gate_act);
  assign inc      = cnt_en & tick & ~(wr_lo | wr_hi);

  gmt_core u_core (
    .clk(clk), .rst_n(rst_n), .mode(ctl.mode), .inc(inc),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .clr_flag(clr_flag), .wdata(wdata),
    .lo(lo_q), .hi(hi_q), .flag(ovf_flag), .ovf_evt(ovf_evt));

  assign ctl_q = ctl;
  assign irq   = ovf_flag & ctl.int_en;
endmodule

// File: rtl/gmt_timer_chk.sv
module gmt_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] waddr,
  input logic [7:0] lo_q,
  input logic [7:0] hi_q,
  input logic [7:0] ctl_q,
  input logic       ovf_flag,
  input logic       cnt_en,
  input logic       ovf_evt
);
  logic cnt_wr;
  assign cnt_wr = wr_en & ~waddr[1];

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && ctl_q[1:0] == 2'd2) |=> (lo_q == $past(hi_q)));
  // R4
  reload_hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[1:0] == 2'd2 && !cnt_wr) |=> $stable(hi_q));
  // R5
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[1:0] == 2'd3 && !cnt_wr) |=> $stable({hi_q, lo_q}));
  // R6
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_wr) |=> $stable({hi_q, lo_q}));
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);
  // R9
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag && !ovf_evt) |=> !ovf_flag);
  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && waddr == 2'd3 && !ovf_evt) |=> !ovf_flag);
endmodule

bind gmt_timer gmt_timer_chk u_chk (.*);

// File: tb/sim_gmt_timer.sv
module sim_gmt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 0, rst_n = 0, wr_en = 0, gate_pin = 0, count_pin = 1;
  logic [1:0] waddr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] lo_q, hi_q, ctl_q;
  logic ovf_flag, irq;
  int checks = 0, errors = 0;
  logic [7:0] ctl_base;

  always #(CLK_PERIOD/2) clk = ~clk;

  gmt_timer #(.PRE_DIV(DIV)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    waddr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  // m increments when the tick is every clock; ctl_base supplies other bits
  task automatic run_win(int m);
    wr(2, ctl_base | 8'h04);
    repeat (m-1) @(negedge clk);
    wr(2, ctl_base);
    @(negedge clk);
  endtask

  function automatic logic [16:0] mdl(int md, logic [7:0] l, logic [7:0] h);
    logic [12:0] v13; logic [15:0] v16;
    case (md)
      0: begin
        v13 = {h, l[4:0]};
        return {v13 == 13'h1fff, 8'(((v13 + 1) >> 5) & 13'hff), l[7:5], 5'((v13 + 1) & 13'h1f)};
      end
      1: begin v16 = {h, l}; return {v16 == 16'hffff, 16'(v16 + 1)}; end
      2: return (l == 8'hff) ? {1'b1, h, h} : {1'b0, h, 8'(l + 1)};
      default: return {1'b0, h, l};
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [16:0] st; logic [7:0] l0, h0; logic eo;
    logic [7:0] starts_l[4]; logic [7:0] starts_h[4];
    starts_l = '{8'hfc, 8'hff, 8'h3e, 8'h00};
    starts_h = '{8'hff, 8'hff, 8'h80, 8'h00};
    repeat (3) @(negedge clk);
    // R1
    chk("R1", {lo_q, hi_q, ctl_q, 6'd0, ovf_flag, irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 sweep with every-clock ticks
    for (int md = 0; md < 3; md++)
      for (int s = 0; s < 4; s++)
        for (int m = 1; m <= 9; m++) begin
          ctl_base = 8'h40 | 8'(md);
          wr(2, ctl_base); wr(3, 0);
          l0 = starts_l[s] ^ 8'(m << 5); h0 = starts_h[s] - 8'(md);
          wr(0, l0); wr(1, h0);
          eo = 0;
          for (int k = 0; k < m; k++) begin
            st = mdl(md, l0, h0); eo |= st[16]; h0 = st[15:8]; l0 = st[7:0];
          end
          run_win(m);
          chk(md == 0 ? "R2" : md == 1 ? "R3" : "R4", {15'd0, ovf_flag, hi_q, lo_q},
              {15'd0, eo, h0, l0});
        end

    // R5 hold mode
    ctl_base = 8'h43; wr(2, ctl_base); wr(0, 8'h12); wr(1, 8'h34);
    run_win(6);
    chk("R5", {hi_q, lo_q}, 16'h3412);

    // R10 irq gating
    ctl_base = 8'h41; wr(2, ctl_base); wr(3, 0); wr(0, 8'hff); wr(1, 8'hff);
    run_win(1);
    chk("R10 ie=0", {ovf_flag, irq}, 2'b10);
    wr(2, 8'hc1); @(negedge clk);
    chk("R10 ie=1", {ovf_flag, irq}, 2'b11);
    // R9 clear
    wr(3, 0);
    chk("R9 clear", {ovf_flag, irq}, 2'b00);
    // R9 set wins
    ctl_base = 8'h41; wr(2, ctl_base); wr(0, 8'hff); wr(1, 8'hff);
    wr(2, ctl_base | 8'h04); wr(3, 0); wr(2, ctl_base); @(negedge clk);
    chk("R9 set wins", ovf_flag, 1'b1);
    wr(3, 0);

    // R8 write during count wins
    ctl_base = 8'h41; wr(0, 0); wr(1, 0); wr(2, ctl_base | 8'h04);
    repeat (3) @(negedge clk);
    wr(0, 8'h55);
    chk("R8 write wins", lo_q, 8'h55);
    wr(2, ctl_base);

    // R7 prescaled clock: 3*DIV enabled edges -> 3 steps
    ctl_base = 8'h01; wr(2, ctl_base); wr(0, 0); wr(1, 0);
    run_win(3*DIV);
    chk("R7 prescale", {hi_q, lo_q}, 16'd3);

    // R6 gate high-active, pin low -> no count
    gate_pin = 0; ctl_base = 8'h49; wr(2, ctl_base); wr(0, 0); repeat (4) @(negedge clk);
    run_win(5);
    chk("R6 gate closed", lo_q, 8'd0);
    gate_pin = 1; repeat (4) @(negedge clk);
    run_win(5);
    chk("R6 gate open", lo_q, 8'd5);
    // R6 inverted polarity
    ctl_base = 8'h59; wr(2, ctl_base); wr(0, 0);
    run_win(5);
    chk("R6 pol closed", lo_q, 8'd0);
    gate_pin = 0; repeat (4) @(negedge clk);
    run_win(4);
    chk("R6 pol open", lo_q, 8'd4);
    // R6 run off
    wr(2, 8'h41); wr(0, 0); repeat (6) @(negedge clk);
    chk("R6 run off", lo_q, 8'd0);

    // R7 external falling edges
    count_pin = 0; repeat (5) @(negedge clk);
    wr(2, 8'h25); wr(0, 0);
    count_pin = 1; repeat (5) @(negedge clk);
    chk("R7 rise ignored", lo_q, 8'd0);
    for (int k = 0; k < 3; k++) begin
      count_pin = 0; repeat (4) @(negedge clk);
      count_pin = 1; repeat (4) @(negedge clk);
    end
    chk("R7 ext falls", lo_q, 8'd3);
    wr(2, 8'h21);
    count_pin = 0; repeat (5) @(negedge clk);
    chk("R7 ext when stopped", lo_q, 8'd3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule